// File: doc/BRIEF.md
# Snoopy Line Controller with a Relaxed Stale State

This block is the coherence controller for one core's small direct-mapped cache on a shared snooping bus. It uses the four usual MESI states and adds a fifth, STALE. When another core takes ownership of a line, a local copy in S, E or M does not have to be dropped. It can move to STALE instead and keep its data. Relaxed loads may read a STALE copy without using the bus and may get an outdated value. Acquire loads and stores must treat a STALE copy as absent.

The core sends one request at a time: a relaxed load, an acquire load, a store or a barrier. A barrier turns every STALE line into Invalid in one cycle and puts nothing on the bus. Each STALE line also turns itself Invalid after a fixed number of cycles, so a core spinning on a flag with relaxed loads still sees the new value in the end. When `stale_en` is low, snooped ownership requests invalidate lines as in plain MESI.

The state encoding is I=0, S=1, E=2, M=3, STALE=4. Each line holds one data word and has its own tag and timer. The request machine has three states:
- IDLE accepts requests and answers hits and barriers.
- WRITEBACK writes back a Modified victim that has a different tag.
- FETCH issues the miss command and waits for the bus acknowledge.

The transitions are:
- IDLE→WRITEBACK on a miss whose victim is M.
- IDLE→FETCH on any other miss.
- WRITEBACK→FETCH when the bus acknowledges.
- FETCH→IDLE when the bus acknowledges.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. `req_ready` is 1, `rsp_valid` and `bus_req_valid` are 0, a snoop sees no copy, and the first load misses.
- R2: A load miss drives `bus_req_cmd` = 0 (read) with the request address, and holds the request until `bus_ack`. The fill installs E when `bus_fill_shared` is 0 and S when it is 1. The response comes in the cycle after the acknowledge, with `rsp_hit`=0 and the fill data.
- R3: A load that hits, or a store to an E or M line, responds in the cycle after acceptance with `rsp_hit`=1 and no bus request. A store hit leaves the line M and returns the written data.
- R4: A store to an S line with a matching tag drives `bus_req_cmd` = 2 (upgrade). After the acknowledge the line is M and holds the store data.
- R5: On a snooped read (`snp_cmd` = 0), a matching line in S, E or M raises `snp_shared`. An M line also raises `snp_flush` with its data on `snp_data`. M and E lines drop to S. A tag mismatch gives no response.
- R6: On a snooped read-for-ownership (1) or upgrade (2) with `stale_en` high, a matching S, E or M line moves to STALE. An M line flushes its data.
- R7: A relaxed load (`req_op` = 0) to a STALE line hits and returns the held data, even after memory has changed.
- R8: An acquire load (`req_op` = 1) to a STALE line misses and re-reads the line with command 0.
- R9: A store (`req_op` = 2) to a STALE line issues command 1 (read-for-ownership), never an upgrade.
- R10: A barrier (`req_op` = 3) turns every STALE line into Invalid in one cycle. It responds with `rsp_hit`=1, uses no bus, and leaves S, E and M lines unchanged.
- R11: A STALE line becomes Invalid `STALE_TIMEOUT` cycles after entering STALE.
- R12: With `stale_en` low, a snooped read-for-ownership or upgrade makes the matching line Invalid, so a later relaxed load misses.
- R13: A miss whose victim is M with another tag first drives command 3 (writeback) with the victim address and data, then the fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stale_en | input | 1 | Allows snooped ownership to leave STALE copies |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Request accepted at this edge (idle, no snoop) |
| req_op | input | 2 | 0 relaxed load, 1 acquire load, 2 store, 3 barrier |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | 1 when served without a bus transfer |
| rsp_data | output | DATA_W | Load or store data |
| bus_req_valid | output | 1 | Bus request held until acknowledged |
| bus_req_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 writeback |
| bus_req_addr | output | ADDR_W | Bus request address |
| bus_req_data | output | DATA_W | Writeback data |
| bus_ack | input | 1 | Bus completes the current request |
| bus_fill_data | input | DATA_W | Fill data with the acknowledge |
| bus_fill_shared | input | 1 | Another cache keeps a copy |
| snp_valid | input | 1 | Snooped transaction from another core |
| snp_cmd | input | 2 | Snooped command, same encoding as the bus |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | Matching S, E or M copy present |
| snp_flush | output | 1 | Supplying dirty data |
| snp_data | output | DATA_W | Supplied data |

## Verification
- **Hits and barriers:** the response is due one cycle after the acceptance edge.
- **Misses:** the response is due one cycle after the edge that samples `bus_ack`.
- **Snoop outputs:** these are combinational in the snooped cycle. The new line state shows at the following edge.

The bench drives inputs on falling edges and samples each result at the next falling edge, which is the first point where the response register is visible. The stale timeout is checked once well inside and once well beyond `STALE_TIMEOUT`, using only the hit or miss of later loads.

// File: rtl/coh_pkg.sv
package coh_pkg;
    typedef enum logic [2:0] {
        LS_I     = 3'd0,
        LS_S     = 3'd1,
        LS_E     = 3'd2,
        LS_M     = 3'd3,
        LS_STALE = 3'd4
    } lstate_e;

    typedef enum logic [1:0] {
        OP_LD  = 2'd0,
        OP_LDA = 2'd1,
        OP_ST  = 2'd2,
        OP_BAR = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        BC_RD  = 2'd0,
        BC_RDX = 2'd1,
        BC_UPG = 2'd2,
        BC_WB  = 2'd3
    } bcmd_e;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_WB    = 2'd1,
        FS_FETCH = 2'd2
    } fsm_e;
endpackage

// File: rtl/coh_stale_timer.sv
module coh_stale_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !armed) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = armed && (cnt_q == LAST);
endmodule

// File: rtl/coh_hit_decode.sv
module coh_hit_decode
    import coh_pkg::*;
(
    input  op_e     op,
    input  lstate_e state,
    input  logic    tag_match,
    input  logic    stale_en,
    output logic    hit,
    output bcmd_e   miss_cmd
);
    logic coherent;

    assign coherent = tag_match && (state == LS_S || state == LS_E || state == LS_M);

    always_comb begin
        hit      = 1'b0;
        miss_cmd = BC_RD;
        unique case (op)
            OP_LD:  hit = coherent || (tag_match && stale_en && state == LS_STALE);
            OP_LDA: hit = coherent;
            OP_ST: begin
                hit      = tag_match && (state == LS_E || state == LS_M);
                miss_cmd = (tag_match && state == LS_S) ? BC_UPG : BC_RDX;
            end
            OP_BAR: hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
    import coh_pkg::*;
(
    input  logic    snp_valid,
    input  bcmd_e   cmd,
    input  lstate_e state,
    input  logic    tag_match,
    input  logic    stale_en,
    output logic    upd,
    output lstate_e nxt,
    output logic    shared,
    output logic    flush
);
    logic present;

    assign present = snp_valid && tag_match &&
                     (state == LS_S || state == LS_E || state == LS_M);

    always_comb begin
        upd    = 1'b0;
        nxt    = state;
        shared = present;
        flush  = 1'b0;
        unique case (cmd)
            BC_RD: begin
                flush = present && state == LS_M;
                upd   = present && state != LS_S;
                nxt   = LS_S;
            end
            BC_RDX, BC_UPG: begin
                flush = present && state == LS_M;
                if (present) begin
                    upd = 1'b1;
                    nxt = stale_en ? LS_STALE : LS_I;
                end else if (snp_valid && tag_match && state == LS_STALE && !stale_en) begin
                    upd = 1'b1;
                    nxt = LS_I;
                end
            end
            BC_WB: shared = 1'b0;
        endcase
    end
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
    import coh_pkg::*;
#(
    parameter int NUM_LINES     = 4,
    parameter int ADDR_W        = 8,
    parameter int DATA_W        = 16,
    parameter int STALE_TIMEOUT = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stale_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [DATA_W-1:0] bus_req_data,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_fill_data,
    input  logic              bus_fill_shared,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_flush,
    output logic [DATA_W-1:0] snp_data
);
    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    lstate_e           st_q  [NUM_LINES];
    logic [TAG_W-1:0]  tag_q [NUM_LINES];
    logic [DATA_W-1:0] dat_q [NUM_LINES];
    logic [NUM_LINES-1:0] expire;

    fsm_e fsm_q, fsm_d;
    op_e               op_q;
    bcmd_e             cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    // Per-line stale timers
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_timer
        coh_stale_timer #(.LIMIT(STALE_TIMEOUT)) u_timer (
            .clk    (clk),
            .rst_n  (rst_n),
            .armed  (st_q[g] == LS_STALE),
            .expire (expire[g])
        );
    end

    // Snoop side
    logic [IDX_W-1:0] sidx;
    logic [TAG_W-1:0] stag;
    logic             s_upd;
    lstate_e          s_nxt;

    assign sidx = snp_addr[IDX_W-1:0];
    assign stag = snp_addr[ADDR_W-1:IDX_W];

    coh_snoop_unit u_snoop (
        .snp_valid (snp_valid),
        .cmd       (bcmd_e'(snp_cmd)),
        .state     (st_q[sidx]),
        .tag_match (tag_q[sidx] == stag),
        .stale_en  (stale_en),
        .upd       (s_upd),
        .nxt       (s_nxt),
        .shared    (snp_shared),
        .flush     (snp_flush)
    );
    assign snp_data = dat_q[sidx];

    // Request side
    logic [IDX_W-1:0] ridx;
    logic [TAG_W-1:0] rtag;
    logic             rtag_match, r_hit, fire, need_wb;
    bcmd_e            r_cmd;
    op_e              r_op;
    logic [IDX_W-1:0] idx_q;

    assign r_op       = op_e'(req_op);
    assign ridx       = req_addr[IDX_W-1:0];
    assign rtag       = req_addr[ADDR_W-1:IDX_W];
    assign rtag_match = (tag_q[ridx] == rtag);
    assign idx_q      = addr_q[IDX_W-1:0];

    coh_hit_decode u_dec (
        .op        (r_op),
        .state     (st_q[ridx]),
        .tag_match (rtag_match),
        .stale_en  (stale_en),
        .hit       (r_hit),
        .miss_cmd  (r_cmd)
    );

    assign req_ready = (fsm_q == FS_IDLE) && !snp_valid;
    assign fire      = req_valid && req_ready;
    assign need_wb   = (st_q[ridx] == LS_M) && !rtag_match;

    // Next-state process
    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q)
            FS_IDLE:  if (fire && !r_hit) fsm_d = need_wb ? FS_WB : FS_FETCH;
            FS_WB:    if (bus_ack) fsm_d = FS_FETCH;
            FS_FETCH: if (bus_ack) fsm_d = FS_IDLE;
            default:  fsm_d = FS_IDLE;
        endcase
    end

    // State register and request latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q   <= FS_IDLE;
            op_q    <= OP_LD;
            cmd_q   <= BC_RD;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            fsm_q <= fsm_d;
            if (fire) begin
                op_q    <= r_op;
                cmd_q   <= r_cmd;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
        end
    end

    // Output process: bus request
    always_comb begin
        bus_req_valid = 1'b0;
        bus_req_cmd   = BC_RD;
        bus_req_addr  = addr_q;
        bus_req_data  = '0;
        unique case (fsm_q)
            FS_IDLE: ;
            FS_WB: begin
                bus_req_valid = 1'b1;
                bus_req_cmd   = BC_WB;
                bus_req_addr  = {tag_q[idx_q], idx_q};
                bus_req_data  = dat_q[idx_q];
            end
            FS_FETCH: begin
                bus_req_valid = 1'b1;
                bus_req_cmd   = cmd_q;
            end
            default: ;
        endcase
    end

    // Line array: timers, barrier, hits, fills, then snoops (snoop wins)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                st_q[i]  <= LS_I;
                tag_q[i] <= '0;
                dat_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (st_q[i] == LS_STALE && (expire[i] || (fire && r_op == OP_BAR))) begin
                    st_q[i] <= LS_I;
                end
            end
            if (fire && r_hit && r_op == OP_ST) begin
                st_q[ridx]  <= LS_M;
                dat_q[ridx] <= req_wdata;
            end
            if (fsm_q == FS_WB && bus_ack) begin
                st_q[idx_q] <= LS_I;
            end
            if (fsm_q == FS_FETCH && bus_ack) begin
                tag_q[idx_q] <= addr_q[ADDR_W-1:IDX_W];
                if (op_q == OP_ST) begin
                    st_q[idx_q]  <= LS_M;
                    dat_q[idx_q] <= wdata_q;
                end else begin
                    st_q[idx_q]  <= bus_fill_shared ? LS_S : LS_E;
                    dat_q[idx_q] <= bus_fill_data;
                end
            end
            if (s_upd) begin
                st_q[sidx] <= s_nxt;
            end
        end
    end

    // Response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (fire && r_hit) begin
                rsp_valid <= 1'b1;
                rsp_hit   <= 1'b1;
                unique case (r_op)
                    OP_ST:         rsp_data <= req_wdata;
                    OP_BAR:        rsp_data <= '0;
                    OP_LD, OP_LDA: rsp_data <= dat_q[ridx];
                endcase
            end else if (fsm_q == FS_FETCH && bus_ack) begin
                rsp_valid <= 1'b1;
                rsp_hit   <= 1'b0;
                rsp_data  <= (op_q == OP_ST) ? wdata_q : bus_fill_data;
            end
        end
    end

    // Assertions
    logic any_stale;
    always_comb begin
        any_stale = 1'b0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (st_q[i] == LS_STALE) any_stale = 1'b1;
        end
    end

    a_r10_barrier_purges: assert property (@(posedge clk) disable iff (!rst_n)
        fire && r_op == OP_BAR |=> !any_stale);

    a_r9_store_stale_rdx: assert property (@(posedge clk) disable iff (!rst_n)
        fire && r_op == OP_ST && rtag_match && st_q[ridx] == LS_STALE
        |=> bus_req_valid && bus_req_cmd == BC_RDX);

    a_r2_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && !bus_ack |=> bus_req_valid && $stable(bus_req_cmd) && $stable(bus_req_addr));

    a_r5_flush_leaves_modified: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush |=> st_q[$past(sidx)] != LS_M);

    a_r12_no_stale_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && !stale_en && (snp_cmd == BC_RDX || snp_cmd == BC_UPG) && st_q[sidx] != LS_STALE
        |=> st_q[$past(sidx)] != LS_STALE);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
        a_r11_timeout_drops: assert property (@(posedge clk) disable iff (!rst_n)
            expire[g] && st_q[g] == LS_STALE |=> st_q[g] != LS_STALE);
    end
endmodule

// File: tb/coh_line_ctrl_tb.sv
`timescale 1ns/1ps
module coh_line_ctrl_tb;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int TMO    = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stale_en = 1'b1;
    logic req_valid = 1'b0, req_ready;
    logic [1:0] req_op = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic rsp_valid, rsp_hit;
    logic [DATA_W-1:0] rsp_data;
    logic bus_req_valid;
    logic [1:0] bus_req_cmd;
    logic [ADDR_W-1:0] bus_req_addr;
    logic [DATA_W-1:0] bus_req_data;
    logic bus_ack = 1'b0;
    logic [DATA_W-1:0] bus_fill_data = '0;
    logic bus_fill_shared = 1'b0;
    logic snp_valid = 1'b0;
    logic [1:0] snp_cmd = '0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic snp_shared, snp_flush;
    logic [DATA_W-1:0] snp_data;

    always #5 clk = ~clk;

    coh_line_ctrl #(.NUM_LINES(4), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STALE_TIMEOUT(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .stale_en(stale_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd),
        .bus_req_addr(bus_req_addr), .bus_req_data(bus_req_data),
        .bus_ack(bus_ack), .bus_fill_data(bus_fill_data), .bus_fill_shared(bus_fill_shared),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_shared(snp_shared), .snp_flush(snp_flush), .snp_data(snp_data)
    );

    int n_tests = 0;
    int n_fail  = 0;
    logic [DATA_W-1:0] mem [256];

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // kind: 0 LD, 1 LDA, 2 ST, 3 BAR, 4 snoop RD, 5 snoop RDX, 6 snoop UPG, 7 memory poke
    // bus: 0 RD, 1 RDX, 2 UPG, 4 none
    typedef struct packed {
        logic [2:0]  kind;
        logic [7:0]  addr;
        logic [15:0] wd;
        logic        hit;
        logic [15:0] data;
        logic [2:0]  bus;
        logic        shr;
        logic        wb;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 8'h04, 16'h0000, 1'b0, 16'h1004, 3'd0, 1'b0, 1'b0},
        '{3'd0, 8'h04, 16'h0000, 1'b1, 16'h1004, 3'd4, 1'b0, 1'b0},
        '{3'd2, 8'h04, 16'hAAAA, 1'b1, 16'hAAAA, 3'd4, 1'b0, 1'b0},
        '{3'd4, 8'h04, 16'h0000, 1'b1, 16'hAAAA, 3'd4, 1'b0, 1'b1},
        '{3'd0, 8'h04, 16'h0000, 1'b1, 16'hAAAA, 3'd4, 1'b0, 1'b0},
        '{3'd5, 8'h04, 16'h0000, 1'b1, 16'h0000, 3'd4, 1'b0, 1'b0},
        '{3'd7, 8'h04, 16'hBBBB, 1'b0, 16'h0000, 3'd4, 1'b0, 1'b0},
        '{3'd0, 8'h04, 16'h0000, 1'b1, 16'hAAAA, 3'd4, 1'b0, 1'b0},
        '{3'd1, 8'h04, 16'h0000, 1'b0, 16'hBBBB, 3'd0, 1'b1, 1'b0},
        '{3'd6, 8'h04, 16'h0000, 1'b1, 16'h0000, 3'd4, 1'b0, 1'b0},
        '{3'd2, 8'h04, 16'hCCCC, 1'b0, 16'hCCCC, 3'd1, 1'b0, 1'b0},
        '{3'd0, 8'h08, 16'h0000, 1'b0, 16'h1008, 3'd0, 1'b0, 1'b1},
        '{3'd5, 8'h08, 16'h0000, 1'b1, 16'h0000, 3'd4, 1'b0, 1'b0},
        '{3'd3, 8'h00, 16'h0000, 1'b1, 16'h0000, 3'd4, 1'b0, 1'b0},
        '{3'd0, 8'h08, 16'h0000, 1'b0, 16'h1008, 3'd0, 1'b1, 1'b0},
        '{3'd2, 8'h08, 16'hDDDD, 1'b0, 16'hDDDD, 3'd2, 1'b0, 1'b0},
        '{3'd5, 8'h08, 16'h0000, 1'b1, 16'hDDDD, 3'd4, 1'b0, 1'b1},
        '{3'd0, 8'h08, 16'h0000, 1'b1, 16'hDDDD, 3'd4, 1'b0, 1'b0},
        '{3'd0, 8'h05, 16'h0000, 1'b0, 16'h1005, 3'd0, 1'b0, 1'b0},
        '{3'd4, 8'h05, 16'h0000, 1'b1, 16'h0000, 3'd4, 1'b0, 1'b0},
        '{3'd2, 8'h05, 16'h1234, 1'b0, 16'h1234, 3'd2, 1'b0, 1'b0},
        '{3'd1, 8'h04, 16'h0000, 1'b0, 16'hCCCC, 3'd0, 1'b0, 1'b0},
        '{3'd4, 8'h09, 16'h0000, 1'b0, 16'h0000, 3'd4, 1'b0, 1'b0},
        '{3'd2, 8'h0D, 16'h5555, 1'b0, 16'h5555, 3'd1, 1'b0, 1'b1},
        '{3'd0, 8'h05, 16'h0000, 1'b0, 16'h1234, 3'd0, 1'b0, 1'b1}
    };

    function automatic string tag_of(input vec_t v);
        if (v.kind == 3'd3) return "R10";
        if (v.kind == 3'd4) return "R5";
        if (v.kind >= 3'd5) return "R6";
        if (v.wb) return "R13";
        if (v.hit) return (v.kind == 3'd0) ? "R3/R7" : "R3";
        if (v.bus == 3'd2) return "R4";
        if (v.bus == 3'd1) return "R9";
        return (v.kind == 3'd1) ? "R2/R8" : "R2";
    endfunction

    task automatic wait_bus(input string tag);
        for (int w = 0; w < 20 && !bus_req_valid; w++) @(negedge clk);
        chk(bus_req_valid, tag, 0, 1);
    endtask

    task automatic do_local(input logic [1:0] op, input logic [7:0] a, input logic [15:0] wd,
                            input logic ehit, input logic [15:0] edata, input logic [2:0] ebus,
                            input logic shr, input logic ewb, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (ehit) begin
            chk(rsp_valid && rsp_hit && !bus_req_valid, tag, {rsp_valid, rsp_hit, bus_req_valid}, 3'b110);
            chk(rsp_data == edata, tag, rsp_data, edata);
        end else begin
            if (ewb) begin
                wait_bus(tag);
                chk(bus_req_cmd == 2'd3, tag, bus_req_cmd, 3);
                mem[bus_req_addr] = bus_req_data;
                bus_ack = 1'b1;
                @(negedge clk);
                bus_ack = 1'b0;
            end
            wait_bus(tag);
            chk(bus_req_cmd == ebus[1:0] && bus_req_addr == a, tag,
                {bus_req_cmd, bus_req_addr}, {ebus[1:0], a});
            bus_fill_data = mem[a]; bus_fill_shared = shr; bus_ack = 1'b1;
            @(negedge clk);
            bus_ack = 1'b0;
            chk(rsp_valid && !rsp_hit && rsp_data == edata, tag, rsp_data, edata);
        end
    endtask

    task automatic do_snoop(input logic [1:0] c, input logic [7:0] a, input logic eshr,
                            input logic efl, input logic [15:0] edata, input string tag);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
        #1;
        chk(snp_shared == eshr && snp_flush == efl, tag, {snp_shared, snp_flush}, {eshr, efl});
        if (efl) begin
            chk(snp_data == edata, tag, snp_data, edata);
            mem[a] = snp_data;
        end
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = 16'h1000 + 16'(a);
        do_reset();

        // R1: reset state
        chk(req_ready && !rsp_valid && !bus_req_valid, "R1", {req_ready, rsp_valid, bus_req_valid}, 3'b100);
        do_snoop(2'd0, 8'h04, 1'b0, 1'b0, 16'h0, "R1");

        // table walk, stale enabled
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VEC[i];
            if (v.kind == 3'd7) mem[v.addr] = v.wd;
            else if (v.kind >= 3'd4) do_snoop(2'(v.kind - 3'd4), v.addr, v.hit, v.wb, v.data, tag_of(v));
            else do_local(v.kind[1:0], v.addr, v.wd, v.hit, v.data, v.bus, v.shr, v.wb, tag_of(v));
        end

        // R11 timeout, plus R10 barrier leaving coherent lines alone
        do_reset();
        do_local(2'd0, 8'h10, 16'h0, 1'b0, mem[8'h10], 3'd0, 1'b0, 1'b0, "R1");
        do_local(2'd0, 8'h11, 16'h0, 1'b0, mem[8'h11], 3'd0, 1'b0, 1'b0, "R2");
        do_snoop(2'd1, 8'h10, 1'b1, 1'b0, 16'h0, "R6");
        repeat (15) @(negedge clk);
        do_local(2'd0, 8'h10, 16'h0, 1'b1, mem[8'h10], 3'd4, 1'b0, 1'b0, "R11");
        repeat (TMO + 5) @(negedge clk);
        do_local(2'd0, 8'h10, 16'h0, 1'b0, mem[8'h10], 3'd0, 1'b0, 1'b0, "R11");
        do_local(2'd3, 8'h00, 16'h0, 1'b1, 16'h0, 3'd4, 1'b0, 1'b0, "R10");
        do_local(2'd0, 8'h11, 16'h0, 1'b1, mem[8'h11], 3'd4, 1'b0, 1'b0, "R10");

        // R12 plain MESI
        stale_en = 1'b0;
        do_reset();
        do_local(2'd0, 8'h20, 16'h0, 1'b0, mem[8'h20], 3'd0, 1'b0, 1'b0, "R12");
        do_snoop(2'd1, 8'h20, 1'b1, 1'b0, 16'h0, "R12");
        do_local(2'd0, 8'h20, 16'h0, 1'b0, mem[8'h20], 3'd0, 1'b0, 1'b0, "R12");
        do_snoop(2'd2, 8'h20, 1'b1, 1'b0, 16'h0, "R12");
        do_local(2'd0, 8'h20, 16'h0, 1'b0, mem[8'h20], 3'd0, 1'b1, 1'b0, "R12");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule